// File: doc/BRIEF.md
# Static memory controller with wait states

This block runs one read or one write at a time on an asynchronous static memory bus whose strobes are all active low: a chip select, an output enable, a write enable and one select per byte lane. A host presents a request (address, write data, byte enables, direction) with a valid signal. The controller accepts it only when idle and then sequences the strobes over a number of system clocks set by four wait-state inputs. On a read it returns the captured data with a one-cycle done pulse. On a write it returns the done pulse alone.

The four wait-state inputs are 4 bits each. Two of them shape reads: a delay from chip select to the output enable, and an end count that sets the output-enable pulse width. The other two shape writes in the same way for the write enable. Any setting that gives a strobe pulse shorter than three clocks is stretched to three. On writes the byte-lane selects start one clock before the write enable and end one clock after it. Address and write data stay on the bus for one clock after the last strobe has been released. The wait-state inputs are sampled when a request is accepted and are held for the whole cycle.

Top module: `smc_wait_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, `mem_cs_n`, `mem_oe_n`, `mem_we_n` and every bit of `mem_bls_n` are 1, `mem_dq_oe` is 0, and `rsp_done` is 0 except in the cycle that directly follows a completed access.
- R2: Cycle 0 is the first clock in which `mem_cs_n` is low, which is the clock after acceptance. On a read, `mem_oe_n` and the enabled lane selects go low in cycle D, where D is `cfg_oe_dly`.
- R3: On a read, `mem_oe_n` stays low for W = max(3, `cfg_rd_end` − D + 1) cycles, and `mem_cs_n` and `mem_oe_n` both return high on the same clock edge.
- R4: Read data is sampled from `mem_dq_in` on the edge that ends the last cycle with `mem_oe_n` low. It appears on `rsp_rdata` in the following cycle, and `rsp_done` is high for exactly that one cycle.
- R5: On a write with E = `cfg_we_dly`, the enabled lane selects go low in cycle E and `mem_we_n` goes low in cycle E + 1.
- R6: On a write, `mem_we_n` stays low for V = max(3, `cfg_wr_end` − E + 1) cycles. The lane selects stay low for V + 2 cycles, ending one cycle after `mem_we_n` rises, and `mem_cs_n` rises together with the lane selects.
- R7: On a write, `mem_dq_oe` is 1 and `mem_dq_out` carries the request's write data from cycle 0 through cycle E + V + 2, which is one cycle after the lane selects rise. `mem_addr` carries the request address from cycle 0 until the done pulse on both reads and writes, and `mem_dq_oe` is never 1 while `mem_oe_n` is low.
- R8: On a write, `rsp_done` is high for exactly one cycle, in cycle E + V + 3.
- R9: While an access is in progress, `req_ready` is 0 and any `req_valid` is ignored: no new access starts and the bus address does not change.
- R10: Lane select bit i (covering data bits 8i+7 down to 8i) goes low only if `req_be[i]` was 1 for that access. Otherwise it stays 1 for the whole access.
- R11: The wait-state inputs and the request fields are sampled at acceptance. Changing them during an access does not alter that access's strobe timing, address, data or lane selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every wait state is one period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; a valid request is taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Request address |
| req_wdata | input | DATA_W (16) | Write data |
| req_be | input | DATA_W/8 (2) | Byte-lane enables, bit i for data bits 8i+7:8i |
| cfg_oe_dly | input | CFG_W (4) | Read: cycles from chip select low to output enable low |
| cfg_rd_end | input | CFG_W (4) | Read: end count; pulse width is end − delay + 1, at least 3 |
| cfg_we_dly | input | CFG_W (4) | Write: cycles from chip select low to lane selects low |
| cfg_wr_end | input | CFG_W (4) | Write: end count; write-enable width is end − delay + 1, at least 3 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (16) | Captured read data, valid with rsp_done after a read |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls_n | output | DATA_W/8 (2) | Byte-lane selects, active low |
| mem_addr | output | ADDR_W (16) | Memory address |
| mem_dq_out | output | DATA_W (16) | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads; 0 leaves the bus released |
| mem_dq_in | input | DATA_W (16) | Data from memory |

## Verification
Every strobe is a register decoded from a single cycle counter and a set of window bounds latched at acceptance. A wrong counter value, a wrong bound or a wrong state therefore shows up at the pins in the very cycle it arises, as a strobe edge one clock early or late. A wrong return to idle shows up one cycle later as a misplaced or missing done pulse. A capture made on the wrong edge is visible on `rsp_rdata` in the done cycle, because the bench puts valid memory data only on the capture edge. A failure to lock out requests or to latch the configuration changes `mem_addr` or the strobe pattern within the same access.

// File: rtl/smc_pkg.sv
package smc_pkg;

  // Sequencer phase: idle, or running one read or one write access
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } sq_state_e;

  // Shortest strobe pulse the bus allows, in clocks
  localparam int unsigned MIN_STROBE = 3;

  // Number of window bounds computed per access
  localparam int unsigned WIN_FIELDS = 6;

endpackage

// File: rtl/smc_timing_calc.sv
// Converts the wait-state fields of one access into cycle-count window bounds.
// Counts are relative to cycle 0, the first clock with chip select low.
module smc_timing_calc
  import smc_pkg::*;
#(
  parameter int CFG_W = 4,
  parameter int CNT_W = CFG_W + 2
) (
  input  logic             is_wr,
  input  logic [CFG_W-1:0] dly,
  input  logic [CFG_W-1:0] fin,
  output logic [CNT_W-1:0] str_first,
  output logic [CNT_W-1:0] str_last,
  output logic [CNT_W-1:0] lane_first,
  output logic [CNT_W-1:0] lane_last,
  output logic [CNT_W-1:0] cs_last,
  output logic [CNT_W-1:0] op_last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_W = CNT_W'(MIN_STROBE);

  logic [CNT_W-1:0] dly_x;
  logic [CNT_W-1:0] fin_x;
  logic [CNT_W-1:0] wid;

  // Strobe width, stretched to the bus minimum
  always_comb begin
    dly_x = CNT_W'(dly);
    fin_x = CNT_W'(fin);
    if ((fin_x + ONE) >= (dly_x + MIN_W)) begin
      wid = fin_x + ONE - dly_x;
    end else begin
      wid = MIN_W;
    end
  end

  always_comb begin
    if (is_wr) begin
      // lanes lead the write enable by one and trail it by one, then one hold cycle
      lane_first = dly_x;
      str_first  = dly_x + ONE;
      str_last   = dly_x + wid;
      lane_last  = dly_x + wid + ONE;
      cs_last    = dly_x + wid + ONE;
      op_last    = dly_x + wid + ONE + ONE;
    end else begin
      // lanes follow the output enable; chip select releases with it
      lane_first = dly_x;
      str_first  = dly_x;
      str_last   = dly_x + wid - ONE;
      lane_last  = dly_x + wid - ONE;
      cs_last    = dly_x + wid - ONE;
      op_last    = dly_x + wid - ONE;
    end
  end

endmodule

// File: rtl/smc_seq.sv
// Access sequencer: phase register, cycle counter and latched window bounds.
// Exposes next-cycle values so the strobe registers can be loaded in step.
module smc_seq
  import smc_pkg::*;
#(
  parameter int CNT_W = 6,
  localparam int WIN_W = WIN_FIELDS * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             acc_wr,
  input  logic [WIN_W-1:0] win_calc,
  output logic             busy_q,
  output logic             last_q,
  output logic             rd_last_q,
  output logic             busy_d,
  output logic             wr_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic [WIN_W-1:0] win_d
);

  sq_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] op_last_q;
  logic             load;

  assign op_last_q = win_q[CNT_W-1:0];
  assign load      = accept && (st_q == SQ_IDLE);

  // Next-state process
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (accept) begin
          st_d  = acc_wr ? SQ_WRITE : SQ_READ;
          cnt_d = '0;
        end
      end
      default: begin
        if (cnt_q == op_last_q) begin
          st_d  = SQ_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    endcase
    win_d = load ? win_calc : win_q;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      win_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (load) begin
        win_q <= win_calc;
      end
    end
  end

  assign busy_q    = (st_q != SQ_IDLE);
  assign last_q    = busy_q && (cnt_q == op_last_q);
  assign rd_last_q = last_q && (st_q == SQ_READ);
  assign busy_d    = (st_d != SQ_IDLE);
  assign wr_d      = (st_d == SQ_WRITE);

  // R9
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= op_last_q));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_q) |=> busy_q && $stable(st_q));

endmodule

// File: rtl/smc_strobe_gen.sv
// Registered strobe outputs decoded from the next cycle count and window bounds.
module smc_strobe_gen #(
  parameter int CNT_W = 6,
  parameter int BE_W  = 2,
  localparam int SW_W = 5 * CNT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy_d,
  input  logic            wr_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [SW_W-1:0] bounds_d,
  input  logic [BE_W-1:0] be_d,
  output logic            cs_n_q,
  output logic            oe_n_q,
  output logic            we_n_q,
  output logic [BE_W-1:0] bls_n_q,
  output logic            dq_oe_q
);

  logic [CNT_W-1:0] str_first, str_last, lane_first, lane_last, cs_last;
  logic             in_str, in_lane;
  logic             cs_low_d, oe_low_d, we_low_d, dq_oe_d;
  logic [BE_W-1:0]  bls_n_d;

  assign str_first  = bounds_d[5*CNT_W-1 -: CNT_W];
  assign str_last   = bounds_d[4*CNT_W-1 -: CNT_W];
  assign lane_first = bounds_d[3*CNT_W-1 -: CNT_W];
  assign lane_last  = bounds_d[2*CNT_W-1 -: CNT_W];
  assign cs_last    = bounds_d[CNT_W-1:0];

  always_comb begin
    in_str   = busy_d && (cnt_d >= str_first) && (cnt_d <= str_last);
    in_lane  = busy_d && (cnt_d >= lane_first) && (cnt_d <= lane_last);
    cs_low_d = busy_d && (cnt_d <= cs_last);
    oe_low_d = in_str && !wr_d;
    we_low_d = in_str && wr_d;
    dq_oe_d  = busy_d && wr_d;
  end

  // one select per byte lane
  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign bls_n_d[i] = !(in_lane && be_d[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      bls_n_q <= '1;
      dq_oe_q <= 1'b0;
    end else begin
      cs_n_q  <= !cs_low_d;
      oe_n_q  <= !oe_low_d;
      we_n_q  <= !we_low_d;
      bls_n_q <= bls_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  // R3
  oe_cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n_q) |-> $rose(cs_n_q));

  // R5
  we_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n_q) |-> (!cs_n_q && $past(!cs_n_q)));

  // R6
  cs_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> !cs_n_q);

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> !dq_oe_q);

  // R7
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n_q && !we_n_q));

endmodule

// File: rtl/smc_datapath.sv
// Request capture, read data capture and the done pulse.
module smc_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              last_q,
  input  logic              rd_last_q,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [BE_W-1:0]   be_d,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);

  logic [BE_W-1:0] be_q;

  assign be_d = accept ? req_be : be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (rd_last_q) begin
        rdata_q <= mem_dq_in;
      end
      done_q <= last_q;
    end
  end

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/smc_wait_ctrl.sv
// Static memory controller: single accesses with programmable strobe timing.
module smc_wait_ctrl
  import smc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CFG_W  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int CNT_W = CFG_W + 2,
  localparam int WIN_W = WIN_FIELDS * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic [CFG_W-1:0]  cfg_oe_dly,
  input  logic [CFG_W-1:0]  cfg_rd_end,
  input  logic [CFG_W-1:0]  cfg_we_dly,
  input  logic [CFG_W-1:0]  cfg_wr_end,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [BE_W-1:0]   mem_bls_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              busy_q, last_q, rd_last_q;
  logic              busy_d, wr_d, accept;
  logic [CNT_W-1:0]  cnt_d;
  logic [WIN_W-1:0]  win_calc, win_d;
  logic [CFG_W-1:0]  sel_dly, sel_fin;
  logic [CNT_W-1:0]  c_str_first, c_str_last, c_lane_first, c_lane_last, c_cs_last, c_op_last;
  logic [BE_W-1:0]   be_d;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign sel_dly   = req_write ? cfg_we_dly : cfg_oe_dly;
  assign sel_fin   = req_write ? cfg_wr_end : cfg_rd_end;

  smc_timing_calc #(.CFG_W(CFG_W), .CNT_W(CNT_W)) calc_i (
    .is_wr      (req_write),
    .dly        (sel_dly),
    .fin        (sel_fin),
    .str_first  (c_str_first),
    .str_last   (c_str_last),
    .lane_first (c_lane_first),
    .lane_last  (c_lane_last),
    .cs_last    (c_cs_last),
    .op_last    (c_op_last)
  );

  assign win_calc = {c_str_first, c_str_last, c_lane_first, c_lane_last, c_cs_last, c_op_last};

  smc_seq #(.CNT_W(CNT_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .acc_wr    (req_write),
    .win_calc  (win_calc),
    .busy_q    (busy_q),
    .last_q    (last_q),
    .rd_last_q (rd_last_q),
    .busy_d    (busy_d),
    .wr_d      (wr_d),
    .cnt_d     (cnt_d),
    .win_d     (win_d)
  );

  smc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .last_q    (last_q),
    .rd_last_q (rd_last_q),
    .mem_dq_in (mem_dq_in),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .be_d      (be_d),
    .rdata_q   (rsp_rdata),
    .done_q    (rsp_done)
  );

  smc_strobe_gen #(.CNT_W(CNT_W), .BE_W(BE_W)) strb_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .busy_d   (busy_d),
    .wr_d     (wr_d),
    .cnt_d    (cnt_d),
    .bounds_d (win_d[WIN_W-1:CNT_W]),
    .be_d     (be_d),
    .cs_n_q   (mem_cs_n),
    .oe_n_q   (mem_oe_n),
    .we_n_q   (mem_we_n),
    .bls_n_q  (mem_bls_n),
    .dq_oe_q  (mem_dq_oe)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && (&mem_bls_n) && !mem_dq_oe));

endmodule

// File: tb/smc_wait_ctrl_tb_top.sv
module smc_wait_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [15:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic [3:0]  cfg_oe_dly, cfg_rd_end, cfg_we_dly, cfg_wr_end;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n;
  logic [1:0]  mem_bls_n;
  logic [15:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int op_num = 0;

  smc_wait_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .cfg_oe_dly (cfg_oe_dly),
    .cfg_rd_end (cfg_rd_end),
    .cfg_we_dly (cfg_we_dly),
    .cfg_wr_end (cfg_wr_end),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_bls_n  (mem_bls_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL R1 watchdog: cycles=%0d expected < %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic check_vec(input string req, input int k, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s op=%0d cycle=%0d actual=%h expected=%h", req, op_num, k, act, exp);
    end
  endtask

  // one access with strobe pattern checked in every cycle up to the done pulse
  task automatic run_op(input bit wr, input int d, input int f, input bit noise);
    int          wid, done_k;
    logic [15:0] a, wd, rv;
    logic [1:0]  be;
    bit          e_cs, e_oe, e_we, e_lane, e_dq, e_done, e_rdy;
    logic [31:0] ev, av;
    string       tag;
    wid    = ((f + 1 - d) >= 3) ? (f + 1 - d) : 3;
    done_k = wr ? (d + wid + 3) : (d + wid);
    a      = 16'(op_num * 16'h0137 + 16'h0a00);
    wd     = 16'(op_num * 16'h2b1d + 16'h0055);
    rv     = a ^ 16'hc3a5;
    be     = 2'(op_num % 4);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = wd;
    req_be    = be;
    if (wr) begin
      cfg_we_dly = 4'(d); cfg_wr_end = 4'(f);
      cfg_oe_dly = 4'(15 - d); cfg_rd_end = 4'(15 - f);
    end else begin
      cfg_oe_dly = 4'(d); cfg_rd_end = 4'(f);
      cfg_we_dly = 4'(15 - d); cfg_wr_end = 4'(15 - f);
    end
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      // R9 R11: keep requesting and disturb every sampled input during the access
      req_valid  = 1'b1;
      req_write  = !wr;
      req_addr   = ~a;
      req_wdata  = ~wd;
      req_be     = ~be;
      cfg_oe_dly = ~cfg_oe_dly; cfg_rd_end = ~cfg_rd_end;
      cfg_we_dly = ~cfg_we_dly; cfg_wr_end = ~cfg_wr_end;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k <= done_k; k++) begin
      if (wr) begin
        e_cs   = (k <= d + wid + 1);
        e_oe   = 1'b0;
        e_we   = (k >= d + 1) && (k <= d + wid);
        e_lane = (k >= d) && (k <= d + wid + 1);
        e_dq   = (k <= d + wid + 2);
        tag    = noise ? "R5/R6/R8/R9/R10/R11" : "R5/R6/R8/R10";
      end else begin
        e_cs   = (k <= d + wid - 1);
        e_oe   = (k >= d) && (k <= d + wid - 1);
        e_we   = 1'b0;
        e_lane = e_oe;
        e_dq   = 1'b0;
        tag    = noise ? "R2/R3/R9/R10/R11" : "R2/R3/R10";
      end
      e_done = (k == done_k);
      e_rdy  = (k == done_k);
      ev = {25'd0, !e_cs, !e_oe, !e_we, ~({2{e_lane}} & be), e_dq, e_done};
      av = {25'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_bls_n, mem_dq_oe, rsp_done};
      check_vec(tag, k, av, ev);
      check_vec("R9 ready", k, {31'd0, req_ready}, {31'd0, e_rdy});
      // R7 address held for the whole access
      check_vec("R7 addr", k, {16'd0, mem_addr}, {16'd0, a});
      if (wr && e_dq) check_vec("R7 wdata", k, {16'd0, mem_dq_out}, {16'd0, wd});
      if (!wr && e_done) check_vec("R4 rdata", k, {16'd0, rsp_rdata}, {16'd0, rv});
      // R4: valid memory data only on the capture edge
      mem_dq_in = (!wr && k == d + wid - 1) ? rv : (~rv ^ 16'(k));
      if (noise) req_valid = (k + 1 < done_k);
      @(negedge clk);
    end
    req_valid = 1'b0;
    // R1 back to idle after the done pulse
    check_vec("R1 idle", done_k + 1,
              {26'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_bls_n, mem_dq_oe},
              {26'd0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0});
    op_num = op_num + 1;
  endtask

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_addr   = '0;
    req_wdata  = '0;
    req_be     = '0;
    cfg_oe_dly = '0; cfg_rd_end = '0; cfg_we_dly = '0; cfg_wr_end = '0;
    mem_dq_in  = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_vec("R1 reset", 0,
              {24'd0, req_ready, rsp_done, mem_cs_n, mem_oe_n, mem_we_n, mem_bls_n, mem_dq_oe},
              {24'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_vec("R1 after release", 0,
              {24'd0, req_ready, rsp_done, mem_cs_n, mem_oe_n, mem_we_n, mem_bls_n, mem_dq_oe},
              {24'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0});
    // full sweep of both wait-state pairs, reads then writes
    for (int d = 0; d < 16; d++) begin
      for (int f = 0; f < 16; f++) begin
        run_op(1'b0, d, f, ((d * 16 + f) % 7) == 3);
      end
    end
    for (int d = 0; d < 16; d++) begin
      for (int f = 0; f < 16; f++) begin
        run_op(1'b1, d, f, ((d * 16 + f) % 7) == 5);
      end
    end
    summary();
    $finish;
  end

endmodule